// File: doc/BRIEF.md
# Priority Daisy-Chain Interrupt Node

This block is the peripheral end of a priority interrupt chain. It sits between an upstream chain port, toward the processor, and a downstream chain port, toward devices of lower priority. While the node is idle, the request line from below is forwarded up. The acknowledge and end-of-service lines from above are forwarded down.

When the local logic asks for service, the node first takes the chain. This cuts off the lower devices' request and acknowledge. Only after that does it pull its own request line low. When the processor acknowledges, the node answers in the same cycle by enabling its bus driver with a switch-set service address. When the acknowledge ends, it releases the bus, drops its request and marks its service routine as running. The chain stays cut for the whole routine.

The node frees the chain on the rising edge of the end-of-service pulse. It absorbs that pulse, so the pulse never reaches the lower devices. A node nearer the processor can therefore interrupt a lower node's routine, and routines nest in chain order. The bus pad is high-impedance whenever `bus_en` is low.

Top module: `chain_irq_node`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, the node is idle. `bus_en` is 0, `bus_data` is 0, and the chain lines pass through as in R2.
- R2: When idle, the node is transparent. `up_irq_n` equals `dn_irq_n`, `dn_iak_n` equals `up_iak_n`, and `dn_ise_n` equals `up_ise_n`, all combinationally.
- R3: `dev_req` sampled high on a clock edge, with the node idle and `up_iak_n` high, takes the chain on that edge. From then on `dn_iak_n` is held high and `up_irq_n` no longer follows `dn_irq_n`. `up_irq_n` goes low (active) one clock later.
- R4: While the node holds an unanswered request and `up_iak_n` is low, `bus_en` is 1 and `bus_data` equals `isr_addr_sw`, in the same cycle. At every other time `bus_en` is 0 and `bus_data` is 0.
- R5: When `up_iak_n` returns high after an acknowledge, `bus_en` falls in the same cycle. `up_irq_n` goes high on the next clock edge, and the service routine is then marked running.
- R6: While the routine runs, the chain stays cut. `dn_iak_n` stays high whatever `up_iak_n` does, and a low `dn_irq_n` is not forwarded (`up_irq_n` stays high).
- R7: While the routine runs, a low `up_ise_n` is not forwarded (`dn_ise_n` stays high). On the first clock edge that sees `up_ise_n` high after at least one cycle low, the node returns to idle and R2 applies again.
- R8: A `dev_req` pulse is held pending if it arrives during a service routine, or while idle with `up_iak_n` low. It is raised as a new request (R3) once the node is idle and `up_iak_n` is high.
- R9: While the node is requesting but not yet acknowledged, `up_ise_n` is still forwarded to `dn_ise_n`, and a pulse on it does not cancel the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dev_req | input | 1 | Local service request, one-cycle pulse per request |
| isr_addr_sw | input | 16 | Switch-set service routine address |
| up_irq_n | output | 1 | Request toward the processor, active low |
| up_iak_n | input | 1 | Acknowledge from the processor, active low |
| up_ise_n | input | 1 | End-of-service pulse from the processor, active low |
| dn_irq_n | input | 1 | Request from lower devices, active low |
| dn_iak_n | output | 1 | Acknowledge toward lower devices, active low |
| dn_ise_n | output | 1 | End-of-service toward lower devices, active low |
| bus_data | output | 16 | Data driven onto the shared bus |
| bus_en | output | 1 | Bus driver enable; pad high-impedance when 0 |

## Verification
The bench first runs every combination of chain inputs through the idle node. A node that was not transparent would corrupt requests from lower devices. It then follows one full request, acknowledge and service. It checks that the chain is cut a cycle before the request appears, and that the bus is driven only during the acknowledge. It also checks that the acknowledge and the end-of-service pulse never leak downstream while the routine runs. A design that released the chain at acknowledge end instead of at end of service would let a lower device in early and fail those checks.

Requests that arrive during a routine, or while another device's acknowledge passes through, must be kept and raised later. A design that lost them would never raise the second request. An end-of-service pulse seen while still requesting must pass down and leave the request standing. A design that treated it as its own end would drop the request.

// File: rtl/chain_pkg.sv
// Package: shared state encoding for the daisy-chain interrupt node.
// Assumes: one node per package user; no parameters needed here.
package chain_pkg;
    typedef enum logic [2:0] {
        NODE_IDLE = 3'd0,   // transparent, chain closed
        NODE_OPEN = 3'd1,   // chain cut, own request not yet raised
        NODE_REQ  = 3'd2,   // own request raised, waiting for acknowledge
        NODE_ACK  = 3'd3,   // acknowledge seen, answering on the bus
        NODE_SERV = 3'd4    // service routine running, chain cut
    } node_state_t;
endpackage

// File: rtl/chain_node_fsm.sv
// Module: sequencing of one daisy-chain interrupt node.
// Holds the request/acknowledge/service state, the pending flag and the
// sampled end-of-service line used to find its rising edge.
// Assumes: chain inputs are synchronous to clk and the end-of-service pulse
// is low for at least one full clock period at this node.
module chain_node_fsm
    import chain_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dev_req,
    input  logic        up_iak_n,
    input  logic        up_ise_n,
    output node_state_t state,
    output logic        chain_held,
    output logic        own_irq,
    output logic        ise_block,
    output logic        may_answer
);
    node_state_t state_nx;
    logic        pend_q;
    logic        ise_q;
    logic        start_req;
    logic        ise_rise;

    // Purpose: decide whether a new request may take the chain now.
    always_comb begin
        start_req = (state == NODE_IDLE) && (pend_q || dev_req) && up_iak_n;
        ise_rise  = up_ise_n && !ise_q;
    end

    // Purpose: next-state selection for the node.
    always_comb begin
        state_nx = state;
        unique case (state)
            NODE_IDLE: if (start_req)         state_nx = NODE_OPEN;
            NODE_OPEN: state_nx = up_iak_n ? NODE_REQ : NODE_ACK;
            NODE_REQ:  if (!up_iak_n)         state_nx = NODE_ACK;
            NODE_ACK:  if (up_iak_n)          state_nx = NODE_SERV;
            NODE_SERV: if (ise_rise)          state_nx = NODE_IDLE;
            default:                          state_nx = NODE_IDLE;
        endcase
    end

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= NODE_IDLE;
        else        state <= state_nx;
    end

    // Purpose: remember a request that could not start at once.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend_q <= 1'b0;
        else if (start_req) pend_q <= 1'b0;
        else if (dev_req)   pend_q <= 1'b1;
    end

    // Purpose: previous value of the end-of-service line for edge finding.
    always_ff @(posedge clk) begin
        if (!rst_n) ise_q <= 1'b1;
        else        ise_q <= up_ise_n;
    end

    // Purpose: status decode used by the gating and bus driver blocks.
    always_comb begin
        chain_held = (state != NODE_IDLE);
        own_irq    = (state == NODE_REQ) || (state == NODE_ACK);
        ise_block  = (state == NODE_ACK) || (state == NODE_SERV);
        may_answer = (state == NODE_OPEN) || (state == NODE_REQ) || (state == NODE_ACK);
    end

    // R3: the own request is only ever raised after a cycle of cut chain.
    a_r3_open_before_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (state == NODE_REQ) |-> ($past(state) == NODE_OPEN || $past(state) == NODE_REQ));
endmodule

// File: rtl/chain_line_gate.sv
// Module: combinational pass/block gating of the three chain lines.
// Assumes: all chain lines are active low; a cut line is driven inactive (1).
module chain_line_gate (
    input  logic chain_held,
    input  logic own_irq,
    input  logic ise_block,
    input  logic dn_irq_n,
    input  logic up_iak_n,
    input  logic up_ise_n,
    output logic up_irq_n,
    output logic dn_iak_n,
    output logic dn_ise_n
);
    // Purpose: merge the own request with the forwarded lower request.
    always_comb begin
        if (own_irq)         up_irq_n = 1'b0;
        else if (chain_held) up_irq_n = 1'b1;
        else                 up_irq_n = dn_irq_n;
    end

    // Purpose: forward or cut acknowledge and end-of-service downward.
    always_comb begin
        dn_iak_n = chain_held ? 1'b1 : up_iak_n;
        dn_ise_n = ise_block  ? 1'b1 : up_ise_n;
    end
endmodule

// File: rtl/chain_addr_drive.sv
// Module: bus driver for the switch-set service address.
// Assumes: the pad ring turns bus_en low into high impedance; data is forced
// to zero while disabled so no stale value reaches the pad.
module chain_addr_drive #(
    parameter int ADDR_W = 16
) (
    input  logic              may_answer,
    input  logic              up_iak_n,
    input  logic [ADDR_W-1:0] isr_addr_sw,
    output logic              bus_en,
    output logic [ADDR_W-1:0] bus_data
);
    // Purpose: answer an acknowledge in the same cycle it appears.
    always_comb begin
        bus_en   = may_answer && !up_iak_n;
        bus_data = bus_en ? isr_addr_sw : '0;
    end
endmodule

// File: rtl/chain_irq_node.sv
// Module: top of one daisy-chain interrupt node.
// Ties the sequencing FSM, the chain line gating and the address driver.
// Assumes: synchronous chain signals, one-cycle dev_req pulses, and an
// end-of-service pulse at least one clock wide.
module chain_irq_node
    import chain_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_req,
    input  logic [ADDR_W-1:0] isr_addr_sw,
    output logic              up_irq_n,
    input  logic              up_iak_n,
    input  logic              up_ise_n,
    input  logic              dn_irq_n,
    output logic              dn_iak_n,
    output logic              dn_ise_n,
    output logic [ADDR_W-1:0] bus_data,
    output logic              bus_en
);
    node_state_t state;
    logic        chain_held;
    logic        own_irq;
    logic        ise_block;
    logic        may_answer;

    chain_node_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .dev_req    (dev_req),
        .up_iak_n   (up_iak_n),
        .up_ise_n   (up_ise_n),
        .state      (state),
        .chain_held (chain_held),
        .own_irq    (own_irq),
        .ise_block  (ise_block),
        .may_answer (may_answer)
    );

    chain_line_gate u_gate (
        .chain_held (chain_held),
        .own_irq    (own_irq),
        .ise_block  (ise_block),
        .dn_irq_n   (dn_irq_n),
        .up_iak_n   (up_iak_n),
        .up_ise_n   (up_ise_n),
        .up_irq_n   (up_irq_n),
        .dn_iak_n   (dn_iak_n),
        .dn_ise_n   (dn_ise_n)
    );

    chain_addr_drive #(.ADDR_W(ADDR_W)) u_drive (
        .may_answer  (may_answer),
        .up_iak_n    (up_iak_n),
        .isr_addr_sw (isr_addr_sw),
        .bus_en      (bus_en),
        .bus_data    (bus_data)
    );

    // R4: the bus is never driven while the service routine runs.
    a_r4_quiet_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        (state == NODE_SERV) |-> !bus_en);

    // R5: the request is released the cycle after the acknowledge ends.
    a_r5_irq_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == NODE_ACK && up_iak_n) |=> up_irq_n);

    // R6: no acknowledge leaks downstream while the chain is cut.
    a_r6_iak_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (state == NODE_SERV) |-> dn_iak_n);

    // R7: the end-of-service pulse is absorbed during service.
    a_r7_ise_swallowed: assert property (@(posedge clk) disable iff (!rst_n)
        (state == NODE_SERV) |-> dn_ise_n);
endmodule

// File: tb/chain_irq_node_tb.sv
// Bench for chain_irq_node: an idle pass-through vector table walked by
// one loop, then directed request, service, pending and reset checks.
module chain_irq_node_tb_top;
    localparam int ADDR_W = 16;
    localparam logic [ADDR_W-1:0] ADDR = 16'hA5C3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              dev_req = 1'b0;
    logic [ADDR_W-1:0] isr_addr_sw = ADDR;
    logic              up_irq_n;
    logic              up_iak_n = 1'b1;
    logic              up_ise_n = 1'b1;
    logic              dn_irq_n = 1'b1;
    logic              dn_iak_n;
    logic              dn_ise_n;
    logic [ADDR_W-1:0] bus_data;
    logic              bus_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // vector: {dn_irq_n, up_iak_n, up_ise_n} -> expected {up_irq_n, dn_iak_n, dn_ise_n}
    localparam logic [5:0] VEC [8] = '{
        6'b000_000, 6'b001_001, 6'b010_010, 6'b011_011,
        6'b100_100, 6'b101_101, 6'b110_110, 6'b111_111
    };

    always #5 clk = ~clk;

    chain_irq_node #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .isr_addr_sw(isr_addr_sw),
        .up_irq_n(up_irq_n), .up_iak_n(up_iak_n), .up_ise_n(up_ise_n),
        .dn_irq_n(dn_irq_n), .dn_iak_n(dn_iak_n), .dn_ise_n(dn_ise_n),
        .bus_data(bus_data), .bus_en(bus_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // advance past a rising edge; inputs change only here, well away from edges
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // acknowledge, release, then end-of-service; leaves the node idle
    task automatic serve_once(input string tag);
        up_iak_n = 1'b0; #1;
        check({tag, " R4 bus_en on ack"}, 32'(bus_en), 32'd1);
        check({tag, " R4 bus_data"}, 32'(bus_data), 32'(ADDR));
        tick();
        up_iak_n = 1'b1; #1;
        check({tag, " R5 bus released"}, 32'(bus_en), 32'd0);
        tick();
        check({tag, " R5 irq dropped"}, 32'(up_irq_n), 32'd1);
        up_ise_n = 1'b0; #1;
        check({tag, " R7 ise swallowed"}, 32'(dn_ise_n), 32'd1);
        tick();
        up_ise_n = 1'b1;
        tick();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        tick(); tick();
        check("R1 bus_en in reset", 32'(bus_en), 32'd0);
        check("R1 bus_data in reset", 32'(bus_data), 32'd0);
        dn_irq_n = 1'b0; #1;
        check("R1 irq passes in reset", 32'(up_irq_n), 32'd0);
        dn_irq_n = 1'b1;
        rst_n = 1'b1;
        tick();
        check("R1 idle after reset", 32'(dn_iak_n), 32'd1);

        // R2: idle pass-through table
        for (int i = 0; i < 8; i++) begin
            {dn_irq_n, up_iak_n, up_ise_n} = VEC[i][5:3];
            tick();
            check($sformatf("R2 vector %0d", i), 32'({up_irq_n, dn_iak_n, dn_ise_n}), 32'(VEC[i][2:0]));
            check($sformatf("R4 idle bus vector %0d", i), 32'(bus_en), 32'd0);
        end
        {dn_irq_n, up_iak_n, up_ise_n} = 3'b111;
        tick();

        // R3: chain cut one cycle before own request
        dn_irq_n = 1'b0;
        dev_req = 1'b1;
        tick();
        dev_req = 1'b0; #1;
        check("R3 lower irq cut", 32'(up_irq_n), 32'd1);
        tick();
        check("R3 own irq raised", 32'(up_irq_n), 32'd0);
        serve_once("first");
        // serve_once checked R6 irq-cut via irq-dropped with dn_irq_n low
        check("R7 idle again, pass-through", 32'(up_irq_n), 32'd0);

        // R6: chain cut during service
        dev_req = 1'b1; tick(); dev_req = 1'b0;
        tick();
        up_iak_n = 1'b0; tick(); up_iak_n = 1'b1; tick();
        up_iak_n = 1'b0; #1;
        check("R6 iak blocked in service", 32'(dn_iak_n), 32'd1);
        check("R6 lower irq blocked", 32'(up_irq_n), 32'd1);
        check("R4 no drive in service", 32'(bus_en), 32'd0);
        up_iak_n = 1'b1;
        // R8: request during service is held
        dev_req = 1'b1; tick(); dev_req = 1'b0;
        up_ise_n = 1'b0; tick(); up_ise_n = 1'b1;
        tick();
        check("R7 pass-through resumes", 32'(up_irq_n), 32'd0);
        tick();
        check("R8 pending opens chain", 32'(up_irq_n), 32'd1);
        tick();
        check("R8 pending request raised", 32'(up_irq_n), 32'd0);
        serve_once("pend1");

        // R8: request while a lower acknowledge passes through
        dn_irq_n = 1'b0;
        up_iak_n = 1'b0;
        dev_req = 1'b1; tick(); dev_req = 1'b0; #1;
        check("R8 lower iak still passes", 32'(dn_iak_n), 32'd0);
        check("R8 still idle", 32'(up_irq_n), 32'd0);
        up_iak_n = 1'b1;
        tick();
        check("R8 held request cuts chain", 32'(up_irq_n), 32'd1);
        tick();
        check("R8 held request raised", 32'(up_irq_n), 32'd0);

        // R9: end-of-service while requesting passes down, request stays
        up_ise_n = 1'b0; #1;
        check("R9 ise forwarded", 32'(dn_ise_n), 32'd0);
        tick();
        up_ise_n = 1'b1;
        tick();
        check("R9 request kept", 32'(up_irq_n), 32'd0);
        serve_once("r9");
        dn_irq_n = 1'b1; #1;
        check("R2 idle at end", 32'(up_irq_n), 32'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule